// File: doc/BRIEF.md
# LCD Common Scan Controller

This block sequences the row (common) and column (segment) drive of a multiplexed LCD panel. It runs from a slow timebase: an enable pulse, `base_tick`, arrives once per period of a 32.768 kHz reference, sampled in the `clk` domain. A two-bit mode field sets how many commons are scanned, which gives a duty of 1/16, 1/9, 1/8 or 1/24. A two-bit operation field switches the display off, blanks it, or shows it. Each row lasts `TICKS_PER_ROW` base ticks. At each row change the block reads that row's segment word from a display RAM. The RAM has a synchronous read port with an 11-bit address.

A group of eight shared pins changes role with the mode. In the three smaller modes they carry segment data. In the 24-common mode they carry commons 16 to 23, and the bias flag requests the higher bias ratio. Every pin is driven with a two-bit phase code {select, polarity}. The polarity flips once per frame, so the panel sees AC drive. Analog bias levels, contrast and pad strength are handled outside this block.

The RAM read port has a fixed latency of one cycle and no back-pressure. `ram_rd_en` is a single-cycle request. The word must appear on `ram_rd_data` at the next clock edge, and the block always accepts it. The block has no other data stream. The mode and operation pins are plain control levels.

Top module: `lcd_com_scan`

## Requirements
- R1: Mode 00 scans 16 commons, 01 scans 9, 10 scans 8 and 11 scans 24. The active row index counts 0, 1, ... N-1 and then returns to 0.
- R2: Commons at or above the active count never receive a select code. In 9-common mode this covers COM9 to COM15, and in 8-common mode COM8 to COM15.
- R3: In modes 00, 01 and 10, shared pin j carries segment data from RAM bit NSEG+j, and `shr_is_com` is 0. In mode 11, shared pin j acts as common 16+j, and `shr_is_com` is 1.
- R4: `bias_fifth` is 1 in mode 11 and 0 in every other mode.
- R5: Operation 00 (off) and operation 10 (reserved) both drive every phase code to 00. They also reset the row to 0 and the polarity to 0. When the display is enabled again, the first row shown is row 0 with polarity 0.
- R6: Operation 01 (blank) keeps the rows advancing and the common codes active. Every segment code, and every shared pin in a segment role, carries select bit 0. Switching between 11 and 01 does not restart the scan.
- R7: Operation 11 (show): the select bit of segment pin k is bit k of the RAM word at address BASE_ADDR + row. The RAM is read with `ram_rd_en` when the row changes. The word is shown two clock edges after the cycle in which the row change is requested.
- R8: A new mode value is applied only when the scan wraps from the last active row back to row 0. A change made mid-frame leaves the current frame's row count and pin roles as they were.
- R9: Each phase code is {select, polarity}. The polarity is 0 in the first frame after enable and toggles at every frame wrap.
- R10: A row lasts exactly TICKS_PER_ROW pulses of `base_tick`. TICKS_PER_ROW-1 pulses leave the row unchanged.
- R11: During reset and after it, all phase codes are 00 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | One-cycle pulse per period of the 32.768 kHz timebase |
| mode | input | 2 | Common count select: 00=16, 01=9, 10=8, 11=24 |
| op | input | 2 | Operation: 00 off, 01 blank, 10 reserved (off), 11 show |
| ram_rd_en | output | 1 | Display RAM read request |
| ram_addr | output | ADDR_W | Display RAM read address, BASE_ADDR + row |
| ram_rd_data | input | NSEG+8 | Row word, valid one cycle after the request |
| com_ph | output | 32 | Phase codes of COM0..COM15, two bits per pin, pin i at [2i+1:2i] |
| seg_ph | output | 2*NSEG | Phase codes of the dedicated segments |
| shr_ph | output | 16 | Phase codes of the eight shared pins |
| shr_is_com | output | 1 | Shared pins are in their common role |
| bias_fifth | output | 1 | 1/5 bias requested (1/4 otherwise) |

## Verification
The hardest case to reach is a mode change that must wait for the frame boundary. Near it, a 16-row frame hands over to a 24-row frame, the shared pins switch from segments to commons, and the polarity flips, all at the same wrap. The bench reaches this by enabling 16-common mode, stepping two rows, and changing the mode mid-frame. It then steps every remaining row, checks that each still shows the old roles, and follows the new frame up to row 16, where the first shared pin must select. The reserved operation code and the switch into blanking mid-scan are driven in the same way, one row at a time.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int ROW_W = 5;

  localparam logic [1:0] MODE_C16 = 2'b00;
  localparam logic [1:0] MODE_C9  = 2'b01;
  localparam logic [1:0] MODE_C8  = 2'b10;
  localparam logic [1:0] MODE_C24 = 2'b11;

  localparam logic [1:0] OP_OFF   = 2'b00;
  localparam logic [1:0] OP_BLANK = 2'b01;
  localparam logic [1:0] OP_RSVD  = 2'b10;
  localparam logic [1:0] OP_ON    = 2'b11;

  typedef struct packed {
    logic             live;
    logic             pol;
    logic             blank;
    logic [1:0]       mode;
    logic [ROW_W-1:0] row;
  } scan_view_t;

  function automatic logic [ROW_W-1:0] last_row(input logic [1:0] m);
    case (m)
      MODE_C16: last_row = ROW_W'(15);
      MODE_C9:  last_row = ROW_W'(8);
      MODE_C8:  last_row = ROW_W'(7);
      default:  last_row = ROW_W'(23);
    endcase
  endfunction
endpackage

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
  import lcd_scan_pkg::*;
#(
  parameter int TICKS_PER_ROW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_tick,
  input  logic             run,
  input  logic [1:0]       mode_in,
  output logic             fetch,
  output logic [ROW_W-1:0] fetch_row,
  output logic [ROW_W-1:0] row_q,
  output logic             pol_q,
  output logic [1:0]       mode_act
);
  localparam int TW = (TICKS_PER_ROW > 1) ? $clog2(TICKS_PER_ROW) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_ROW - 1);

  logic          run_q;
  logic [TW-1:0] tick_cnt;
  logic          start, adv, wrap;

  assign start     = run & ~run_q;
  assign adv       = run & run_q & base_tick & (tick_cnt == TICK_LAST);
  assign wrap      = adv & (row_q == last_row(mode_act));
  assign fetch     = start | adv;
  assign fetch_row = (start | wrap) ? '0 : row_q + ROW_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      tick_cnt <= '0;
      row_q    <= '0;
      pol_q    <= 1'b0;
      mode_act <= MODE_C16;
    end else if (!run) begin
      run_q    <= 1'b0;
      tick_cnt <= '0;
      row_q    <= '0;
      pol_q    <= 1'b0;
      mode_act <= mode_in;
    end else begin
      run_q <= 1'b1;
      if (start) begin
        tick_cnt <= '0;
        row_q    <= '0;
        pol_q    <= 1'b0;
        mode_act <= mode_in;
      end else begin
        if (base_tick)
          tick_cnt <= (tick_cnt == TICK_LAST) ? '0 : tick_cnt + TW'(1);
        if (adv)
          row_q <= fetch_row;
        if (wrap) begin
          pol_q    <= ~pol_q;
          mode_act <= mode_in;
        end
      end
    end
  end

  // R1: the row never passes the last row of the mode in force
  assert_row_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= last_row(mode_act));

  // R5: switching off returns the scan to row 0
  assert_off_row_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> row_q == '0);

  // R8: while running, the mode in force changes only on a frame wrap
  assert_mode_at_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && mode_act != $past(mode_act)) |-> row_q == '0);

  // R9: the polarity changes only when a new frame begins
  assert_pol_at_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && pol_q != $past(pol_q)) |-> row_q == '0);
endmodule

// File: rtl/lcd_scan_fetch.sv
module lcd_scan_fetch
  import lcd_scan_pkg::*;
#(
  parameter int          ADDR_W    = 11,
  parameter int          DATA_W    = 24,
  parameter logic [10:0] BASE_ADDR = 11'h040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              blank_req,
  input  logic [1:0]        mode_in,
  input  logic              fetch,
  input  logic [ROW_W-1:0]  fetch_row,
  input  logic [ROW_W-1:0]  row_q,
  input  logic              pol_q,
  input  logic [1:0]        mode_act,
  output logic              ram_rd_en,
  output logic [ADDR_W-1:0] ram_addr,
  input  logic [DATA_W-1:0] ram_rd_data,
  output scan_view_t        view,
  output logic [DATA_W-1:0] seg_bits
);
  logic pend;

  assign ram_rd_en = fetch;
  assign ram_addr  = ADDR_W'(BASE_ADDR) + ADDR_W'(fetch_row);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      view     <= '0;
      seg_bits <= '0;
    end else begin
      view.blank <= blank_req;
      if (!run) begin
        pend      <= 1'b0;
        view.live <= 1'b0;
        view.pol  <= 1'b0;
        view.row  <= '0;
        view.mode <= mode_in;
        seg_bits  <= '0;
      end else begin
        pend <= fetch;
        if (pend) begin
          seg_bits  <= ram_rd_data;
          view.live <= 1'b1;
          view.row  <= row_q;
          view.pol  <= pol_q;
          view.mode <= mode_act;
        end
      end
    end
  end

  // R7: a returned word is always taken and shown
  assert_show_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && run) |=> view.live);

  // R5: the display goes dark one edge after switch-off
  assert_dark_after_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !view.live);
endmodule

// File: rtl/lcd_scan_drive.sv
module lcd_scan_drive
  import lcd_scan_pkg::*;
#(
  parameter int NCOM = 16,
  parameter int NSEG = 16,
  parameter int NSHR = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  scan_view_t           view,
  input  logic [NSEG+NSHR-1:0] seg_bits,
  output logic [2*NCOM-1:0]    com_ph,
  output logic [2*NSEG-1:0]    seg_ph,
  output logic [2*NSHR-1:0]    shr_ph,
  output logic                 shr_is_com,
  output logic                 bias_fifth
);
  logic            wide;
  logic [NCOM-1:0] com_sel;
  logic [NSHR-1:0] shr_sel;
  logic [NSHR-1:0] shr_row;

  assign wide       = (view.mode == MODE_C24);
  assign shr_is_com = wide;
  assign bias_fifth = wide;

  for (genvar i = 0; i < NCOM; i++) begin : g_com
    assign com_sel[i]        = view.live & (view.row == ROW_W'(i));
    assign com_ph[2*i +: 2]  = view.live ? {com_sel[i], view.pol} : 2'b00;
  end

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    logic on;
    assign on               = view.live & seg_bits[k] & ~view.blank;
    assign seg_ph[2*k +: 2] = view.live ? {on, view.pol} : 2'b00;
  end

  for (genvar j = 0; j < NSHR; j++) begin : g_shr
    assign shr_row[j]       = view.live & wide & (view.row == ROW_W'(NCOM + j));
    assign shr_sel[j]       = wide ? shr_row[j]
                                   : (view.live & seg_bits[NSEG+j] & ~view.blank);
    assign shr_ph[2*j +: 2] = view.live ? {shr_sel[j], view.pol} : 2'b00;
  end

  // R1: at most one common line selected at a time
  assert_one_common_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shr_row, com_sel}));

  // R2: in 9-common mode COM9..COM15 stay unselected
  assert_idle_upper_c9_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (view.mode == MODE_C9) |-> com_sel[NCOM-1:9] == '0);

  // R2: in 8-common mode COM8..COM15 stay unselected
  assert_idle_upper_c8_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (view.mode == MODE_C8) |-> com_sel[NCOM-1:8] == '0);
endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan
  import lcd_scan_pkg::*;
#(
  parameter int          TICKS_PER_ROW = 4,
  parameter int          NSEG          = 16,
  parameter int          ADDR_W        = 11,
  parameter logic [10:0] BASE_ADDR     = 11'h040
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 base_tick,
  input  logic [1:0]           mode,
  input  logic [1:0]           op,
  output logic                 ram_rd_en,
  output logic [ADDR_W-1:0]    ram_addr,
  input  logic [NSEG+8-1:0]    ram_rd_data,
  output logic [2*16-1:0]      com_ph,
  output logic [2*NSEG-1:0]    seg_ph,
  output logic [2*8-1:0]       shr_ph,
  output logic                 shr_is_com,
  output logic                 bias_fifth
);
  localparam int NCOM   = 16;
  localparam int NSHR   = 8;
  localparam int DATA_W = NSEG + NSHR;

  logic             run, blank_req;
  logic             fetch, pol_q;
  logic [ROW_W-1:0] fetch_row, row_q;
  logic [1:0]       mode_act;
  scan_view_t       view;
  logic [DATA_W-1:0] seg_bits;

  assign run       = (op == OP_ON) | (op == OP_BLANK);
  assign blank_req = (op == OP_BLANK);

  lcd_scan_timing #(.TICKS_PER_ROW(TICKS_PER_ROW)) u_timing (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .run(run), .mode_in(mode),
    .fetch(fetch), .fetch_row(fetch_row), .row_q(row_q), .pol_q(pol_q),
    .mode_act(mode_act)
  );

  lcd_scan_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)) u_fetch (
    .clk(clk), .rst_n(rst_n), .run(run), .blank_req(blank_req), .mode_in(mode),
    .fetch(fetch), .fetch_row(fetch_row), .row_q(row_q), .pol_q(pol_q),
    .mode_act(mode_act), .ram_rd_en(ram_rd_en), .ram_addr(ram_addr),
    .ram_rd_data(ram_rd_data), .view(view), .seg_bits(seg_bits)
  );

  lcd_scan_drive #(.NCOM(NCOM), .NSEG(NSEG), .NSHR(NSHR)) u_drive (
    .clk(clk), .rst_n(rst_n), .view(view), .seg_bits(seg_bits),
    .com_ph(com_ph), .seg_ph(seg_ph), .shr_ph(shr_ph),
    .shr_is_com(shr_is_com), .bias_fifth(bias_fifth)
  );

  // R5: off or reserved for two cycles leaves every pin at the neutral code
  assert_off_neutral_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run)) |-> (com_ph == '0 && seg_ph == '0 && shr_ph == '0));
endmodule

// File: tb/test_lcd_com_scan.sv
`timescale 1ns/1ps
module test_lcd_com_scan;
  localparam int          TPR  = 4;
  localparam int          NSEG = 16;
  localparam logic [10:0] BASE = 11'h040;
  localparam int          VW   = 2 + 16 + 2*NSEG + 32;

  // {mode, op, rows per frame}
  localparam logic [8:0] VEC [0:6] = '{
    {2'b00, 2'b11, 5'd16}, {2'b01, 2'b11, 5'd9}, {2'b10, 2'b11, 5'd8},
    {2'b11, 2'b11, 5'd24}, {2'b11, 2'b01, 5'd24}, {2'b00, 2'b01, 5'd16},
    {2'b10, 2'b01, 5'd8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_tick = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [1:0] op = 2'b00;
  logic ram_rd_en;
  logic [10:0] ram_addr;
  logic [NSEG+7:0] ram_rd_data = '0;
  logic [31:0] com_ph;
  logic [2*NSEG-1:0] seg_ph;
  logic [15:0] shr_ph;
  logic shr_is_com, bias_fifth;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lcd_com_scan #(.TICKS_PER_ROW(TPR), .NSEG(NSEG), .ADDR_W(11), .BASE_ADDR(BASE)) i_lcd_com_scan (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .mode(mode), .op(op),
    .ram_rd_en(ram_rd_en), .ram_addr(ram_addr), .ram_rd_data(ram_rd_data),
    .com_ph(com_ph), .seg_ph(seg_ph), .shr_ph(shr_ph),
    .shr_is_com(shr_is_com), .bias_fifth(bias_fifth)
  );

  function automatic logic [NSEG+7:0] ram_word(input logic [10:0] a);
    logic [7:0] b;
    b = a[7:0];
    ram_word = {b ^ 8'h5A, 8'(b * 8'd3 + 8'd1), ~b ^ {b[2:0], 5'b0}};
  endfunction

  always @(posedge clk) if (ram_rd_en) ram_rd_data <= ram_word(ram_addr);

  function automatic logic [VW-1:0] exp_view(input bit live, input int row, input bit pol,
                                             input logic [1:0] m, input bit blank);
    logic [31:0] c;
    logic [2*NSEG-1:0] s;
    logic [15:0] h;
    logic [NSEG+7:0] w;
    bit p;
    w = ram_word(BASE + 11'(row));
    p = live & pol;
    for (int i = 0; i < 16; i++) c[2*i +: 2] = {live && (i == row), p};
    for (int k = 0; k < NSEG; k++) s[2*k +: 2] = {live && w[k] && !blank, p};
    for (int j = 0; j < 8; j++)
      h[2*j +: 2] = (m == 2'b11) ? {live && (16 + j == row), p}
                                 : {live && w[NSEG+j] && !blank, p};
    exp_view = {m == 2'b11, m == 2'b11, h, s, c};
  endfunction

  function automatic logic [VW-1:0] obs();
    obs = {shr_is_com, bias_fifth, shr_ph, seg_ph, com_ph};
  endfunction

  task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int t = 0; t < n; t++) begin
      @(negedge clk) base_tick = 1'b1;
      @(negedge clk) base_tick = 1'b0;
    end
  endtask

  task automatic next_row();
    tick_n(TPR);
    @(negedge clk);
  endtask

  task automatic enable(input logic [1:0] m, input logic [1:0] o);
    @(negedge clk) begin op = 2'b00; mode = m; end
    repeat (3) @(negedge clk);
    op = o;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R11: state during and after reset
    repeat (3) @(negedge clk);
    check("R11 in reset", obs(), exp_view(0, 0, 0, 2'b00, 0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 after reset", obs(), exp_view(0, 0, 0, 2'b00, 0));

    // Table walk: R1 R2 R3 R4 R5 R6 R7 R9
    for (int v = 0; v < 7; v++) begin
      automatic logic [1:0] vm = VEC[v][8:7];
      automatic logic [1:0] vo = VEC[v][6:5];
      automatic int n = int'(VEC[v][4:0]);
      @(negedge clk) begin op = 2'b00; mode = vm; end
      repeat (3) @(negedge clk);
      check("R5 R4 off", obs(), exp_view(0, 0, 0, vm, 0));
      op = vo;
      repeat (2) @(negedge clk);
      check("R1 R7 first row", obs(), exp_view(1, 0, 0, vm, vo == 2'b01));
      for (int r = 1; r <= n; r++) begin
        next_row();
        check((vo == 2'b01) ? "R6 R1 R2 R3 blank scan" : "R7 R1 R2 R3 R9 scan",
              obs(), exp_view(1, r % n, r >= n, vm, vo == 2'b01));
      end
    end

    // R10: row length
    enable(2'b01, 2'b11);
    tick_n(TPR - 1);
    @(negedge clk);
    check("R10 short of row", obs(), exp_view(1, 0, 0, 2'b01, 0));
    tick_n(1);
    @(negedge clk);
    check("R10 row step", obs(), exp_view(1, 1, 0, 2'b01, 0));

    // R5: reserved code behaves as off, restart at row 0
    op = 2'b10;
    repeat (2) @(negedge clk);
    check("R5 reserved dark", obs(), exp_view(0, 0, 0, 2'b01, 0));
    op = 2'b11;
    repeat (2) @(negedge clk);
    check("R5 restart row0", obs(), exp_view(1, 0, 0, 2'b01, 0));

    // R6: blank entered mid-scan keeps the row
    enable(2'b00, 2'b11);
    next_row();
    check("R6 before blank", obs(), exp_view(1, 1, 0, 2'b00, 0));
    op = 2'b01;
    @(negedge clk);
    check("R6 blank same row", obs(), exp_view(1, 1, 0, 2'b00, 1));
    next_row();
    check("R6 blank advances", obs(), exp_view(1, 2, 0, 2'b00, 1));

    // R8: mode change mid-frame waits for the wrap
    enable(2'b00, 2'b11);
    next_row();
    next_row();
    mode = 2'b11;
    for (int r = 3; r < 16; r++) begin
      next_row();
      check("R8 old mode holds", obs(), exp_view(1, r, 0, 2'b00, 0));
    end
    for (int r = 0; r <= 16; r++) begin
      next_row();
      check("R8 R3 R4 new frame", obs(), exp_view(1, r, 1, 2'b11, 0));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule